// File: doc/BRIEF.md
# Lockable Timer Control Register Bank

This block is the register slice of a multi-timer controller. It holds two control words, a primary word that drives the timer channels and a secondary word kept for the channels' secondary settings. It also has a key register that gates a clear port. Software writes either control word through a simple single-cycle register bus. Reads are combinational from the address.

The clear port is a write-one-to-clear path onto the primary word. It is closed out of reset. It opens when a specific 8-bit command is written to the key register, and it closes again when a second command is written there. While the port is closed, a write to it does nothing. Any access to an address the bank does not decode gives a one-cycle error pulse.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset the primary word, the secondary word and the key flag are all zero, and `illegal_o` is low.
- R2: Offset 0x30 holds the primary word. A write stores all `wdata_i` bits, a read returns it, and `main_ctl_o` always equals it.
- R3: Offset 0x34 holds the secondary word as a plain read/write register. Writing it leaves the primary word unchanged.
- R4: On a write to offset 0x38, the command byte is `wdata_i[8:1]`. The value 0xAE sets the key flag. A read of 0x38 returns the flag in bit 0 and zero in all other bits.
- R5: A command byte of 0xEA at offset 0x38 clears the key flag. Any other command byte leaves the flag unchanged.
- R6: While the key flag is set, a write to offset 0x3C clears each primary-word bit whose `wdata_i` bit is 1. All other bits keep their value, and the flag stays set.
- R7: While the key flag is clear, a write to offset 0x3C leaves the primary word unchanged.
- R8: Offset 0x3C reads as zero. Any offset other than 0x30, 0x34, 0x38 and 0x3C reads as zero, and writes to it change no state. Unaligned offsets such as 0x31 count as unmapped.
- R9: `illegal_o` is high for exactly the one cycle that follows a clock edge at which `we_i` or `re_i` was high with an unmapped offset. At all other times it is low.
- R10: Writes take effect at the rising clock edge where `we_i` is high. `rdata_o` follows `addr_i` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe, used only for the illegal-access flag |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from `addr_i` |
| main_ctl_o | output | DATA_W | Primary control word, sent to the timer channels |
| illegal_o | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
The assertions assume that a cycle carries at most one register access, so a clear and a primary-word load never arrive in the same cycle. The bus guarantees this because each cycle presents a single address. They also assume that `addr_i` is valid whenever a strobe is high. The stimulus drives one access per cycle with stable, known address and data, changes inputs only on the falling edge, and places idle cycles with both strobes low between the key, clear and unmapped sequences.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int unsigned OFS_W   = 8;
  localparam int unsigned N_REG   = 4;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned CMD_LSB = 1;

  localparam logic [OFS_W-1:0] OFS_MAIN = 8'h30;
  localparam logic [OFS_W-1:0] OFS_SEC  = 8'h34;
  localparam logic [OFS_W-1:0] OFS_KEY  = 8'h38;
  localparam logic [OFS_W-1:0] OFS_CLR  = 8'h3C;

  localparam logic [CMD_W-1:0] CMD_OPEN = 8'hAE;
  localparam logic [CMD_W-1:0] CMD_SHUT = 8'hEA;

  typedef enum int unsigned {
    IDX_MAIN = 0,
    IDX_SEC  = 1,
    IDX_KEY  = 2,
    IDX_CLR  = 3
  } reg_idx_e;

  typedef struct packed {
    logic clr;
    logic key;
    logic sec;
    logic main;
  } sel_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o,
  output logic              mapped_o
);
  localparam logic [N_REG-1:0][OFS_W-1:0] OFS_TAB = {OFS_CLR, OFS_KEY, OFS_SEC, OFS_MAIN};

  logic [N_REG-1:0] hit;

  for (genvar i = 0; i < N_REG; i++) begin : g_hit
    assign hit[i] = (addr_i == ADDR_W'(OFS_TAB[i]));
  end

  assign sel_o.main = hit[IDX_MAIN];
  assign sel_o.sec  = hit[IDX_SEC];
  assign sel_o.key  = hit[IDX_KEY];
  assign sel_o.clr  = hit[IDX_CLR];
  assign mapped_o   = |hit;
endmodule

// File: rtl/tmr_ctl_lock.sv
module tmr_ctl_lock
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);
  logic [CMD_W-1:0] cmd;
  logic             unused_wdata;

  assign cmd          = wdata_i[CMD_LSB +: CMD_W];
  assign unused_wdata = ^{wdata_i[DATA_W-1:CMD_LSB+CMD_W], wdata_i[CMD_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
    end else if (wr_i) begin
      if (cmd == CMD_OPEN)      open_o <= 1'b1;
      else if (cmd == CMD_SHUT) open_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ctl_word.sv
module tmr_ctl_word #(
  parameter int unsigned DATA_W    = 32,
  parameter bit          CLEARABLE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  if (CLEARABLE) begin : g_w1c
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o <= '0;
      else if (ld_i)  q_o <= wdata_i;
      else if (clr_i) q_o <= q_o & ~wdata_i;
    end
  end else begin : g_plain
    logic unused_clr;
    assign unused_clr = clr_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (ld_i) q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] main_ctl_o,
  output logic              illegal_o
);
  sel_t              sel;
  logic              mapped;
  logic              lock_q;
  logic [DATA_W-1:0] sec_q;

  tmr_ctl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i  (addr_i),
    .sel_o   (sel),
    .mapped_o(mapped)
  );

  tmr_ctl_lock #(.DATA_W(DATA_W)) i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & sel.key),
    .wdata_i(wdata_i),
    .open_o (lock_q)
  );

  tmr_ctl_word #(.DATA_W(DATA_W), .CLEARABLE(1'b1)) i_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (we_i & sel.main),
    .clr_i  (we_i & sel.clr & lock_q),
    .wdata_i(wdata_i),
    .q_o    (main_ctl_o)
  );

  tmr_ctl_word #(.DATA_W(DATA_W), .CLEARABLE(1'b0)) i_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (we_i & sel.sec),
    .clr_i  (1'b0),
    .wdata_i(wdata_i),
    .q_o    (sec_q)
  );

  always_comb begin
    rdata_o = '0;
    if (sel.main)     rdata_o = main_ctl_o;
    else if (sel.sec) rdata_o = sec_q;
    else if (sel.key) rdata_o = DATA_W'(lock_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= (we_i | re_i) & ~mapped;
  end
endmodule

// File: rtl/tmr_ctl_bank_chk.sv
module tmr_ctl_bank_chk
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] main_ctl_o,
  input logic              illegal_o,
  input logic              lock_i
);
  logic at_main, at_key, at_clr;
  logic [CMD_W-1:0] cmd;
  assign at_main = addr_i == ADDR_W'(OFS_MAIN);
  assign at_key  = addr_i == ADDR_W'(OFS_KEY);
  assign at_clr  = addr_i == ADDR_W'(OFS_CLR);
  assign cmd     = wdata_i[CMD_LSB +: CMD_W];

  a_r2_main_only_by_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (at_main || at_clr)) |=> $stable(main_ctl_o));

  a_r4_key_read_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_key |-> (rdata_o[DATA_W-1:1] == '0 && rdata_o[0] == lock_i));

  a_r5_other_cmd_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && at_key && cmd != CMD_OPEN && cmd != CMD_SHUT) |=> $stable(lock_i));

  a_r6_clear_only_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && at_clr) |=> ((main_ctl_o & ~$past(main_ctl_o)) == '0));

  a_r7_locked_clear_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && at_clr && !lock_i) |=> $stable(main_ctl_o));

  a_r8_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_clr |-> rdata_o == '0);

  a_r9_illegal_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(we_i || re_i));
endmodule

bind tmr_ctl_bank tmr_ctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .main_ctl_o(main_ctl_o),
  .illegal_o (illegal_o),
  .lock_i    (lock_q)
);

// File: tb/test_tmr_ctl_bank.sv
module test_tmr_ctl_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] main_ctl_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_main = '0, m_sec = '0;
  logic        m_lock = 1'b0, m_ill = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr_ctl_bank i_tmr_ctl_bank (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i,
    .rdata_o, .main_ctl_o, .illegal_o
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h30:   return m_main;
      8'h34:   return m_sec;
      8'h38:   return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_mapped(input logic [7:0] a);
    return a == 8'h30 || a == 8'h34 || a == 8'h38 || a == 8'h3C;
  endfunction

  task automatic cyc(input logic we, input logic re, input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk_i);
    we_i = we; re_i = re; addr_i = a; wdata_i = d;
    #1 chk(tag, "rdata", rdata_o, m_read(a));
    @(posedge clk_i);
    m_ill = (we || re) && !m_mapped(a);
    if (we) begin
      case (a)
        8'h30: m_main = d;
        8'h34: m_sec = d;
        8'h38: if (d[8:1] == 8'hAE) m_lock = 1'b1; else if (d[8:1] == 8'hEA) m_lock = 1'b0;
        8'h3C: if (m_lock) m_main = m_main & ~d;
        default: ;
      endcase
    end
    #1;
    chk(tag, "main_ctl", main_ctl_o, m_main);
    chk(tag, "illegal", {31'd0, illegal_o}, {31'd0, m_ill});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'd0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 8'h00, 32'd0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "main in reset", main_ctl_o, 32'd0);
    chk("R1", "illegal in reset", {31'd0, illegal_o}, 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    rd(8'h30, "R1"); rd(8'h34, "R1"); rd(8'h38, "R1");

    wr(8'h30, 32'hA5A5_0F0F, "R2"); rd(8'h30, "R2");
    wr(8'h34, 32'h1234_5678, "R3"); rd(8'h34, "R3"); rd(8'h30, "R3");

    wr(8'h3C, 32'hFFFF_FFFF, "R7"); rd(8'h30, "R7");
    wr(8'h38, 32'h55 << 1, "R5"); rd(8'h38, "R5");
    wr(8'h38, 32'hFFFF_FE00 | (32'hAE << 1) | 32'h1, "R4"); rd(8'h38, "R4");
    wr(8'h3C, 32'h0000_0F00, "R6"); rd(8'h30, "R6"); rd(8'h38, "R6");
    rd(8'h3C, "R8");
    wr(8'h38, 32'hAD << 1, "R5"); rd(8'h38, "R5");
    wr(8'h3C, 32'hA000_0001, "R6"); rd(8'h30, "R6");
    wr(8'h38, 32'hEA << 1, "R5"); rd(8'h38, "R5");
    wr(8'h3C, 32'hFFFF_FFFF, "R7"); rd(8'h30, "R7");
    idle("R9");

    wr(8'h40, 32'hDEAD_BEEF, "R8"); idle("R9");
    wr(8'h31, 32'hFFFF_FFFF, "R8"); rd(8'h30, "R8");
    rd(8'h20, "R9"); rd(8'h3B, "R9"); idle("R9");
    rd(8'hFF, "R8");

    wr(8'h30, 32'h0000_0001, "R10"); wr(8'h30, 32'h8000_0000, "R10"); rd(8'h30, "R10");
    wr(8'h34, 32'hCAFE_F00D, "R10"); wr(8'h38, 32'hAE << 1, "R10");
    wr(8'h3C, 32'h8000_0000, "R10"); rd(8'h30, "R10"); rd(8'h34, "R10");
    idle("R10");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule